// File: doc/BRIEF.md
# External DMA Request Generator

This block lives in a small programmable-logic part next to a processor and acts as a peripheral that wants DMA service. It drives an active-low request line toward one DMA channel and follows the matching active-low acknowledge line. Software chooses the request style with a two-bit mode input and then launches a sequence with a low pulse on an active-low start input.

There are three active styles. The first issues sixteen separate requests, each completed by a full handshake. The second issues one request. The third holds the request low continuously until a fixed number of transfers have been acknowledged. A one-cycle done pulse marks the end of every sequence.

The processor can read the count of completed handshakes over a narrow bus that is shared with other devices. The block drives this bus only while both its chip select and its output enable are low.

Top module: `xdreq_gen`

## Requirements
- R1: Mode code 2'b00 is idle: a start strobe in this mode launches nothing, and the request output stays high.
- R2: Mode code 2'b01 issues exactly 16 separate requests per start. Each request is one low period of the request output, ended by an acknowledge.
- R3: Mode code 2'b10 issues exactly one request per start.
- R4: Mode code 2'b11 holds the request output low without a break from launch until the 16th rising edge of the acknowledge input, then releases it.
- R5: In modes 2'b01 and 2'b10, a request stays low until acknowledge is seen low. The next request is not raised while acknowledge is still low.
- R6: A sequence is launched by a falling edge of the start input, after a two-flip-flop synchroniser. Holding start low launches only one sequence.
- R7: The done output pulses high for exactly one cycle at the end of each sequence. In the counted modes this is at the last acknowledge; in demand mode it is at the release of the request.
- R8: A start strobe that arrives while a sequence is running is ignored. The mode is captured at launch, so a change of mode during a sequence has no effect on it.
- R9: A synchronous active-high reset ends any sequence. The request output returns high and done returns low.
- R10: While both chip select and output enable are low, the 4-bit read bus carries the low bits of the completed-handshake count. Otherwise the bus is high-impedance. The count is cleared at launch and kept after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Request style code |
| start_n_i | input | 1 | Launch strobe, active low, asynchronous |
| ack_n_i | input | 1 | DMA acknowledge, active low, asynchronous |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dreq_n_o | output | 1 | DMA request, active low |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rd_bus_io | inout | 4 | Tri-state read bus carrying the handshake count |

## Verification
The hardest cases to reach are the ones where the bench must hold the acknowledge line in a chosen state for a long time. One is keeping acknowledge low after a request has dropped, to show that no new request appears. Another is never acknowledging, to show that the request does not give up. The bench acts as the DMA controller and delays or withholds acknowledge on purpose in these cases. It also fires a second start strobe, with a new mode, while the first request is still waiting for service.

// File: rtl/xdreq_gen.sv
`timescale 1ns/1ps
module xdreq_gen #(
  parameter int BURST_LEN  = 16,
  parameter int DEMAND_LEN = 16,
  parameter int DATA_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        mode_i,
  input  logic              start_n_i,
  input  logic              ack_n_i,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  output logic              dreq_n_o,
  output logic              done_o,
  inout  wire  [DATA_W-1:0] rd_bus_io
);
  localparam int MAX_LEN = (BURST_LEN > DEMAND_LEN) ? BURST_LEN : DEMAND_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [1:0] M_IDLE = 2'b00, M_MULTI = 2'b01, M_DEMAND = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_REQ, S_HOLD} state_t;

  state_t           state_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       start_sync;
  logic [2:0]       ack_sync;
  logic             start_fall, ack_s, ack_rise, busy, last;
  logic [CNT_W-1:0] target;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_sync <= 3'b111;
      ack_sync   <= 3'b111;
    end else begin
      start_sync <= {start_sync[1:0], start_n_i};
      ack_sync   <= {ack_sync[1:0], ack_n_i};
    end
  end

  assign start_fall = start_sync[2] & ~start_sync[1];
  assign ack_s      = ack_sync[1];
  assign ack_rise   = ~ack_sync[2] & ack_sync[1];
  assign busy       = (state_q != S_IDLE);
  assign target     = (mode_q == M_MULTI)  ? CNT_W'(BURST_LEN) :
                      (mode_q == M_DEMAND) ? CNT_W'(DEMAND_LEN) : CNT_W'(1);
  assign last       = (cnt_q + 1'b1) == target;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= S_IDLE;
      mode_q   <= M_IDLE;
      cnt_q    <= '0;
      dreq_n_o <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_fall && mode_i != M_IDLE) begin
          mode_q <= mode_i;
          cnt_q  <= '0;
          if (mode_i == M_DEMAND) begin
            state_q  <= S_HOLD;
            dreq_n_o <= 1'b0;
          end else begin
            state_q <= S_ARM;
          end
        end
        S_ARM: if (ack_s) begin
          state_q  <= S_REQ;
          dreq_n_o <= 1'b0;
        end
        S_REQ: if (!ack_s) begin
          dreq_n_o <= 1'b1;
          cnt_q    <= cnt_q + 1'b1;
          if (last) begin
            state_q <= S_IDLE;
            done_o  <= 1'b1;
          end else begin
            state_q <= S_ARM;
          end
        end
        S_HOLD: if (ack_rise) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q  <= S_IDLE;
            dreq_n_o <= 1'b1;
            done_o   <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_bus_io = (!cs_n_i && !oe_n_i) ? DATA_W'(cnt_q) : {DATA_W{1'bz}};
endmodule

module xdreq_gen_chk #(
  parameter int CNT_W   = 5,
  parameter int MAX_CNT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_n,
  input logic             done,
  input logic             busy,
  input logic [1:0]       mode_q,
  input logic             ack_s,
  input logic [CNT_W-1:0] cnt
);
  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (rst) busy |-> (mode_q != 2'b00)); // R1
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(MAX_CNT)); // R2
  AST_DEMAND_HELD: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy) && mode_q == 2'b11) |-> !req_n); // R4
  AST_RAISE_AFTER_ACK_HIGH: assert property (@(posedge clk) disable iff (rst) ($fell(req_n) && mode_q != 2'b11) |-> $past(ack_s)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(mode_q)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (req_n && !busy && !done)); // R9
endmodule

bind xdreq_gen xdreq_gen_chk #(.CNT_W(CNT_W), .MAX_CNT(MAX_LEN)) u_chk (
  .clk(clk_i), .rst(rst_i), .req_n(dreq_n_o), .done(done_o), .busy(busy),
  .mode_q(mode_q), .ack_s(ack_s), .cnt(cnt_q)
);

// File: tb/xdreq_gen_bench.sv
`timescale 1ns/1ps
module xdreq_gen_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic start_n = 1'b1, ack_n = 1'b1, cs_n = 1'b1, oe_n = 1'b1;
  logic req_n, done;
  wire [3:0] rd_bus;
  int checks = 0, fails = 0, done_cnt = 0, falls = 0;
  logic prev_req = 1'b1;

  always #4 clk = ~clk;

  xdreq_gen u_xdreq_gen (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .start_n_i(start_n), .ack_n_i(ack_n),
    .cs_n_i(cs_n), .oe_n_i(oe_n), .dreq_n_o(req_n), .done_o(done), .rd_bus_io(rd_bus)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (prev_req && !req_n) falls++;
    end
    prev_req = req_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (req_n == lvl) begin ok = 1; break; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_n = 1'b0;
    repeat (4) @(negedge clk);
    start_n = 1'b1;
  endtask

  task automatic serve(input int n, output int served);
    bit ok;
    served = 0;
    for (int i = 0; i < n; i++) begin
      wait_req(1'b0, ok);
      if (!ok) return;
      repeat (3) @(negedge clk);
      ack_n = 1'b0;
      wait_req(1'b1, ok);
      repeat (2) @(negedge clk);
      ack_n = 1'b1;
      repeat (3) @(negedge clk);
      if (!ok) return;
      served++;
    end
  endtask

  task automatic read_bus(output logic [3:0] v);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = rd_bus;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(req_n === 1'b1, "R9 reset request", req_n, 1);
    chk(done === 1'b0, "R9 reset done", done, 0);
    chk(rd_bus === 4'bzzzz || rd_bus === 4'b0000, "R10 deselected bus", rd_bus, 0);
  endtask

  task automatic t_idle_mode();
    int f0 = falls;
    int d0 = done_cnt;
    mode = 2'b00;
    pulse_start();
    repeat (40) @(negedge clk);
    chk(falls == f0, "R1 no request in mode 00", falls - f0, 0);
    chk(done_cnt == d0, "R1 no done in mode 00", done_cnt - d0, 0);
  endtask

  task automatic t_multi();
    int f0 = falls;
    int d0 = done_cnt;
    int s;
    logic [3:0] v;
    mode = 2'b01;
    pulse_start();
    serve(16, s);
    repeat (40) @(negedge clk);
    chk(s == 16, "R2 served requests", s, 16);
    chk(falls - f0 == 16, "R2 request count", falls - f0, 16);
    chk(done_cnt - d0 == 1, "R7 one done in mode 01", done_cnt - d0, 1);
    read_bus(v);
    chk(v == 4'd0, "R10 count low bits after 16", v, 0);
  endtask

  task automatic t_single();
    int f0 = falls;
    int d0 = done_cnt;
    int s;
    logic [3:0] v;
    mode = 2'b10;
    pulse_start();
    serve(1, s);
    repeat (40) @(negedge clk);
    chk(falls - f0 == 1, "R3 one request", falls - f0, 1);
    chk(done_cnt - d0 == 1, "R7 one done in mode 10", done_cnt - d0, 1);
    read_bus(v);
    chk(v == 4'd1, "R10 selected bus value", v, 1);
    @(negedge clk);
    chk(rd_bus !== 4'd1, "R10 bus released when deselected", rd_bus, 0);
  endtask

  task automatic t_handshake_order();
    bit ok;
    int s;
    int f1;
    int d0 = done_cnt;
    mode = 2'b01;
    pulse_start();
    wait_req(1'b0, ok);
    chk(ok, "R5 first request raised", ok, 1);
    repeat (30) @(negedge clk);
    chk(req_n == 1'b0, "R5 request held without ack", req_n, 0);
    ack_n = 1'b0;
    wait_req(1'b1, ok);
    chk(ok, "R5 request dropped on ack", ok, 1);
    f1 = falls;
    repeat (30) @(negedge clk);
    chk(falls == f1 && req_n == 1'b1, "R5 no new request while ack low", falls - f1, 0);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
    serve(15, s);
    repeat (40) @(negedge clk);
    chk(s == 15, "R5 remaining requests served", s, 15);
    chk(done_cnt - d0 == 1, "R7 done after ordered handshakes", done_cnt - d0, 1);
  endtask

  task automatic t_demand();
    bit ok;
    bit held = 1;
    int f0 = falls;
    int d0 = done_cnt;
    mode = 2'b11;
    pulse_start();
    wait_req(1'b0, ok);
    chk(ok, "R4 demand request raised", ok, 1);
    for (int i = 0; i < 16; i++) begin
      repeat (4) @(negedge clk);
      if (req_n != 1'b0) held = 0;
      ack_n = 1'b0;
      repeat (3) @(negedge clk);
      if (i < 15 && req_n != 1'b0) held = 0;
      ack_n = 1'b1;
      if (i < 15) begin
        repeat (2) @(negedge clk);
        if (req_n != 1'b0) held = 0;
      end
    end
    chk(held, "R4 request held through transfers", held, 1);
    wait_req(1'b1, ok);
    chk(ok, "R4 release after 16 edges", ok, 1);
    repeat (40) @(negedge clk);
    chk(falls - f0 == 1, "R4 single low period", falls - f0, 1);
    chk(done_cnt - d0 == 1, "R7 done in demand mode", done_cnt - d0, 1);
  endtask

  task automatic t_busy_start();
    bit ok;
    int s;
    int f0 = falls;
    int d0 = done_cnt;
    mode = 2'b10;
    pulse_start();
    wait_req(1'b0, ok);
    mode = 2'b01;
    pulse_start();
    repeat (10) @(negedge clk);
    serve(1, s);
    repeat (60) @(negedge clk);
    chk(falls - f0 == 1, "R8 restart and mode change ignored", falls - f0, 1);
    chk(done_cnt - d0 == 1, "R8 single done", done_cnt - d0, 1);
  endtask

  task automatic t_start_held();
    int s;
    int f0 = falls;
    mode = 2'b10;
    @(negedge clk); start_n = 1'b0;
    serve(1, s);
    repeat (40) @(negedge clk);
    start_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(falls - f0 == 1, "R6 held start launches once", falls - f0, 1);
  endtask

  task automatic t_reset_mid();
    bit ok;
    int f0;
    int d0;
    mode = 2'b01;
    pulse_start();
    wait_req(1'b0, ok);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_n == 1'b1, "R9 reset releases request", req_n, 1);
    rst = 1'b0;
    f0 = falls; d0 = done_cnt;
    repeat (40) @(negedge clk);
    chk(falls == f0 && done_cnt == d0, "R9 no activity after reset", falls - f0, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_idle_mode();
    t_multi();
    t_single();
    t_handshake_order();
    t_demand();
    t_busy_start();
    t_start_held();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule